// File: doc/BRIEF.md
# SPI Controller Register Bank

This block is the processor-facing half of an SPI master. A simple word-addressed read/write bus reaches ten registers: control, frame size, status, interrupt clear, receive data, transmit data, clock divider, slave select, masked interrupt status and raw interrupt status. Words written to the transmit register queue up in a transmit FIFO that the frame sequencer drains. Words that the sequencer captures are pushed into a receive FIFO that software drains by reading the receive register. The serial shifting itself sits in the sequencer and is not part of this block.

The usable FIFO depth is not fixed. In normal mode both FIFOs hold four words. When the deep-FIFO control bit is set, the depth follows the programmed frame length: short frames get the full capacity, medium frames get half of it and long frames get a quarter of it. Status reports full, full-next, empty and empty-next for each FIFO. Three raw interrupt sources are gated by enable bits that sit at different positions in the control word, and the results are ORed into one interrupt line.

Top module: `spi_regbank`

## Requirements
- R1: After reset, control reads 0x80000102, frame size reads 4, clock divider reads 7, and status reads 0x2440 while `sel_line` is high and `seq_active` is low (bit 13 select line, bit 10 TX empty, bit 6 RX empty).
- R2: Word offsets are 0 control, 1 frame size, 2 status, 3 interrupt clear, 4 RX data, 5 TX data, 6 clock divider, 7 slave select, 8 masked, 9 raw. Offsets 6 and 7 read back what was last written to them. Offsets 3, 5 and anything above 9 read as 0. Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read.
- R3: The FIFO depth is 4 when control bit 29 is clear. When bit 29 is set, the depth is 32 for a frame size of 8 or less, 16 for a frame size of 9 to 16, and 8 otherwise.
- R4: A write to the frame-size register is ignored while control bit 0 (enable) is set, and also when the value in bits 5:0 exceeds 32.
- R5: A TX data write is queued only while TX occupancy is below the depth; otherwise it is dropped. `tx_data` presents the oldest word, `tx_pop` removes it, and `tx_empty` is high when the queue is empty.
- R6: A read of offset 4 returns the oldest RX word and removes it, or returns 0 when the RX FIFO is empty. Any such read clears the overflow status bit 2.
- R7: An `rx_push` while RX occupancy is at or above the depth drops the word and sets status bit 2 and raw bit 2.
- R8: Status FIFO flags for each FIFO are full (occupancy >= depth), full-next (occupancy = depth-1), empty (0) and empty-next (1). The RX flags sit at bits 4,5,6,7 and the TX flags at bits 8,9,10,11.
- R9: A pulse on `xfer_done` sets status bits 0 and 1 and raw bits 0 and 1. A pulse on `xfer_start` clears status bits 0 and 1.
- R10: Masked bit 0 is raw bit 0 AND control bit 5. Masked bit 1 is raw bit 1 AND control bit 4. Masked bit 2 is raw bit 2 AND control bit 6. `irq` is the OR of the three masked bits.
- R11: Writing 1 to bit 0, 1 or 2 of offset 3 clears the matching raw bit. Writes to offsets 2, 4, 8 and 9 change nothing.
- R12: A control write with bit 31 set returns every register to its reset value and empties both FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_pop | input | 1 | Sequencer takes the oldest TX word |
| tx_data | output | 32 | Oldest TX word |
| tx_empty | output | 1 | TX FIFO empty |
| rx_push | input | 1 | Sequencer delivers a received word |
| rx_data | input | 32 | Received word |
| xfer_start | input | 1 | Transfer begun event |
| xfer_done | input | 1 | Transfer completed event |
| seq_active | input | 1 | Sequencer busy, shown in status bit 14 |
| sel_line | input | 1 | Select line level, shown in status bit 13 |
| cfg_enable | output | 1 | Control enable bit |
| cfg_hold_sel | output | 1 | Hold select across frames (control bit 26) |
| cfg_frame_cnt | output | 16 | Frame count (control bits 23:8) |
| cfg_frame_size | output | 6 | Frame length in bits |
| cfg_clk_div | output | 32 | Clock divider register |
| cfg_slave_sel | output | 32 | Slave select register |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus never raises read and write in the same cycle, and that the sequencer pops TX only when `tx_empty` is low. The bench drives one bus operation per cycle and pops only when its model reports a non-empty queue, so it stays inside these assumptions. It also never pushes RX in the same cycle as an RX read, so the order of push and pop is never in question.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int A_CTRL   = 0;
  localparam int A_FSIZE  = 1;
  localparam int A_STAT   = 2;
  localparam int A_ICLR   = 3;
  localparam int A_RXD    = 4;
  localparam int A_TXD    = 5;
  localparam int A_CDIV   = 6;
  localparam int A_SSEL   = 7;
  localparam int A_MASKED = 8;
  localparam int A_RAW    = 9;

  localparam int CB_EN   = 0;
  localparam int CB_RXIE = 4;
  localparam int CB_TXIE = 5;
  localparam int CB_OVIE = 6;
  localparam int CB_HOLD = 26;
  localparam int CB_DEEP = 29;
  localparam int CB_SRST = 31;

  localparam logic [31:0] CTRL_RST  = 32'h8000_0102;
  localparam logic [31:0] FSIZE_RST = 32'd4;
  localparam logic [31:0] CDIV_RST  = 32'd7;
  localparam logic [5:0]  FSIZE_MAX = 6'd32;
endpackage

// File: rtl/spi_depth_sel.sv
module spi_depth_sel #(
  parameter int CAP   = 32,
  parameter int CNT_W = $clog2(CAP) + 1
) (
  input  logic             deep,
  input  logic [5:0]       fsize,
  output logic [CNT_W-1:0] depth
);
  localparam logic [CNT_W-1:0] D_ALL  = CNT_W'(CAP);
  localparam logic [CNT_W-1:0] D_HALF = CNT_W'(CAP / 2);
  localparam logic [CNT_W-1:0] D_QTR  = CNT_W'(CAP / 4);
  localparam logic [CNT_W-1:0] D_STD  = CNT_W'(CAP / 8);

  always_comb begin
    if (!deep)              depth = D_STD;
    else if (fsize <= 6'd8)  depth = D_ALL;
    else if (fsize <= 6'd16) depth = D_HALF;
    else                    depth = D_QTR;
  end
endmodule

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 32,
  parameter int CAP   = 32,
  parameter int CNT_W = $clog2(CAP) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = $clog2(CAP);

  logic [W-1:0]     mem [CAP];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = wr_q + 1'b1;
      if (pop)  rd_d = rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign count = cnt_q;

  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0); // R5
  AST_FIFO_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> cnt_q < CNT_W'(CAP)); // R5
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_rb_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int FIFO_CAP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tx_pop,
  output logic [31:0]       tx_data,
  output logic              tx_empty,
  input  logic              rx_push,
  input  logic [31:0]       rx_data,
  input  logic              xfer_start,
  input  logic              xfer_done,
  input  logic              seq_active,
  input  logic              sel_line,
  output logic              cfg_enable,
  output logic              cfg_hold_sel,
  output logic [15:0]       cfg_frame_cnt,
  output logic [5:0]        cfg_frame_size,
  output logic [31:0]       cfg_clk_div,
  output logic [31:0]       cfg_slave_sel,
  output logic              irq
);
  localparam int CNT_W = $clog2(FIFO_CAP) + 1;

  logic [31:0]      ctrl_q, ctrl_d, fsize_q, fsize_d, cdiv_q, cdiv_d, ss_q, ss_d;
  logic [31:0]      rdata_q, rdata_d, rd_val, status;
  logic             done_q, done_d, ovf_q, ovf_d;
  logic [2:0]       raw_q, raw_d, en_map, masked;
  logic [CNT_W-1:0] depth, tx_cnt, rx_cnt;
  logic [31:0]      rx_head;
  logic             sreset, tx_push, rx_rd, rx_pop, rx_ok;
  logic [3:0]       tx_flags, rx_flags;

  function automatic logic [3:0] fifo_flags(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] d);
    // {empty_next, empty, full_next, full}
    return {c == CNT_W'(1), c == '0, c == d - 1'b1, c >= d};
  endfunction

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  spi_depth_sel #(.CAP(FIFO_CAP), .CNT_W(CNT_W)) u_depth (
    .deep(ctrl_q[CB_DEEP]), .fsize(fsize_q[5:0]), .depth(depth));

  assign sreset  = bus_wr && hit(bus_addr, A_CTRL) && bus_wdata[CB_SRST];
  assign tx_push = bus_wr && hit(bus_addr, A_TXD) && (tx_cnt < depth);
  assign rx_rd   = bus_rd && hit(bus_addr, A_RXD);
  assign rx_pop  = rx_rd && (rx_cnt != '0);
  assign rx_ok   = rx_push && (rx_cnt < depth);

  spi_fifo #(.W(32), .CAP(FIFO_CAP), .CNT_W(CNT_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(sreset), .push(tx_push), .pop(tx_pop),
    .wdata(bus_wdata), .rdata(tx_data), .count(tx_cnt));

  spi_fifo #(.W(32), .CAP(FIFO_CAP), .CNT_W(CNT_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(sreset), .push(rx_ok), .pop(rx_pop),
    .wdata(rx_data), .rdata(rx_head), .count(rx_cnt));

  assign tx_flags = fifo_flags(tx_cnt, depth);
  assign rx_flags = fifo_flags(rx_cnt, depth);
  assign status   = {17'b0, seq_active, sel_line, 1'b0, tx_flags, rx_flags,
                     1'b0, ovf_q, done_q, done_q};
  assign en_map   = {ctrl_q[CB_OVIE], ctrl_q[CB_RXIE], ctrl_q[CB_TXIE]};
  assign masked   = raw_q & en_map;

  always_comb begin
    case (bus_addr)
      ADDR_W'(A_CTRL):   rd_val = ctrl_q;
      ADDR_W'(A_FSIZE):  rd_val = fsize_q;
      ADDR_W'(A_STAT):   rd_val = status;
      ADDR_W'(A_RXD):    rd_val = (rx_cnt != '0) ? rx_head : 32'd0;
      ADDR_W'(A_CDIV):   rd_val = cdiv_q;
      ADDR_W'(A_SSEL):   rd_val = ss_q;
      ADDR_W'(A_MASKED): rd_val = {29'b0, masked};
      ADDR_W'(A_RAW):    rd_val = {29'b0, raw_q};
      default:           rd_val = 32'd0;
    endcase
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    fsize_d = fsize_q;
    cdiv_d  = cdiv_q;
    ss_d    = ss_q;
    done_d  = done_q;
    ovf_d   = ovf_q;
    raw_d   = raw_q;
    rdata_d = bus_rd ? rd_val : rdata_q;
    if (sreset) begin
      ctrl_d  = CTRL_RST;
      fsize_d = FSIZE_RST;
      cdiv_d  = CDIV_RST;
      ss_d    = '0;
      done_d  = 1'b0;
      ovf_d   = 1'b0;
      raw_d   = '0;
    end else begin
      if (bus_wr) begin
        if (hit(bus_addr, A_CTRL)) ctrl_d = bus_wdata;
        if (hit(bus_addr, A_FSIZE) && !ctrl_q[CB_EN] && bus_wdata[5:0] <= FSIZE_MAX)
          fsize_d = bus_wdata;
        if (hit(bus_addr, A_CDIV)) cdiv_d = bus_wdata;
        if (hit(bus_addr, A_SSEL)) ss_d = bus_wdata;
        if (hit(bus_addr, A_ICLR)) raw_d = raw_q & ~bus_wdata[2:0];
      end
      if (rx_rd)      ovf_d = 1'b0;
      if (xfer_start) done_d = 1'b0;
      if (xfer_done) begin
        done_d     = 1'b1;
        raw_d[1:0] = 2'b11;
      end
      if (rx_push && !rx_ok) begin
        ovf_d    = 1'b1;
        raw_d[2] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      fsize_q <= FSIZE_RST;
      cdiv_q  <= CDIV_RST;
      ss_q    <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
      raw_q   <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      fsize_q <= fsize_d;
      cdiv_q  <= cdiv_d;
      ss_q    <= ss_d;
      done_q  <= done_d;
      ovf_q   <= ovf_d;
      raw_q   <= raw_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata      = rdata_q;
  assign tx_empty       = (tx_cnt == '0);
  assign irq            = |masked;
  assign cfg_enable     = ctrl_q[CB_EN];
  assign cfg_hold_sel   = ctrl_q[CB_HOLD];
  assign cfg_frame_cnt  = ctrl_q[23:8];
  assign cfg_frame_size = fsize_q[5:0];
  assign cfg_clk_div    = cdiv_q;
  assign cfg_slave_sel  = ss_q;

  AST_ONE_BUS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R2
  AST_TX_DROP_AT_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit(bus_addr, A_TXD) && tx_cnt >= depth && !tx_pop)
      |=> tx_cnt == $past(tx_cnt)); // R5
  AST_RX_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_cnt == '0) |=> bus_rdata == 32'd0); // R6
  AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt >= depth && !sreset) |=> (raw_q[2] && status[2])); // R7
  AST_FSIZE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit(bus_addr, A_FSIZE) && ctrl_q[CB_EN]) |=> $stable(fsize_q)); // R4
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_q[CB_RXIE] || ctrl_q[CB_TXIE] || ctrl_q[CB_OVIE]) |-> !irq); // R10
  AST_SRST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (tx_cnt == '0 && rx_cnt == '0 && ctrl_q == CTRL_RST)); // R12
endmodule

// File: tb/spi_regbank_bench.sv
module spi_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 0, bus_rd = 0, tx_pop = 0, rx_push = 0;
  logic        xfer_start = 0, xfer_done = 0, seq_active = 0, sel_line = 1;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, rx_data = '0;
  logic [31:0] bus_rdata, tx_data, cfg_clk_div, cfg_slave_sel;
  logic        tx_empty, cfg_enable, cfg_hold_sel, irq;
  logic [15:0] cfg_frame_cnt;
  logic [5:0]  cfg_frame_size;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  spi_regbank u_spi_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty),
    .rx_push(rx_push), .rx_data(rx_data), .xfer_start(xfer_start),
    .xfer_done(xfer_done), .seq_active(seq_active), .sel_line(sel_line),
    .cfg_enable(cfg_enable), .cfg_hold_sel(cfg_hold_sel),
    .cfg_frame_cnt(cfg_frame_cnt), .cfg_frame_size(cfg_frame_size),
    .cfg_clk_div(cfg_clk_div), .cfg_slave_sel(cfg_slave_sel), .irq(irq));

  // behavioural reference
  bit [31:0] m_ctrl, m_fsize, m_cdiv, m_ss;
  bit        m_done, m_ovf;
  bit [2:0]  m_raw;
  bit [31:0] txq[$], rxq[$];

  task automatic m_reset();
    m_ctrl = 32'h8000_0102; m_fsize = 4; m_cdiv = 7; m_ss = 0;
    m_done = 0; m_ovf = 0; m_raw = 0;
    txq.delete(); rxq.delete();
  endtask

  function automatic int m_depth();
    if (!m_ctrl[29]) return 4;
    if (m_fsize[5:0] <= 8) return 32;
    if (m_fsize[5:0] <= 16) return 16;
    return 8;
  endfunction

  function automatic bit [3:0] m_flags(int n);
    int d = m_depth();
    return {n == 1, n == 0, n == d - 1, n >= d};
  endfunction

  function automatic bit [31:0] m_status();
    return {17'b0, seq_active, sel_line, 1'b0, m_flags(txq.size()),
            m_flags(rxq.size()), 1'b0, m_ovf, m_done, m_done};
  endfunction

  function automatic bit [2:0] m_masked();
    return m_raw & {m_ctrl[6], m_ctrl[4], m_ctrl[5]};
  endfunction

  function automatic bit [31:0] m_read(int a);
    case (a)
      0: return m_ctrl;
      1: return m_fsize;
      2: return m_status();
      4: return rxq.size() ? rxq[0] : 0;
      6: return m_cdiv;
      7: return m_ss;
      8: return {29'b0, m_masked()};
      9: return {29'b0, m_raw};
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // one clock: drive, update model, clock, compare at negedge
  task automatic step(bit wr, bit rd, int a, bit [31:0] d, bit pop, bit push,
                      bit [31:0] pd, bit st, bit dn, string tag);
    bit [31:0] exp_rd;
    int dep;
    bit srst;
    dep = m_depth();
    exp_rd = m_read(a);
    if (pop) check("R5 tx_data", tx_data, txq[0]);
    bus_wr = wr; bus_rd = rd; bus_addr = 4'(a); bus_wdata = d;
    tx_pop = pop; rx_push = push; rx_data = pd; xfer_start = st; xfer_done = dn;
    srst = wr && a == 0 && d[31];
    if (srst) m_reset();
    else begin
      if (wr) case (a)
        0: m_ctrl = d;
        1: if (!m_ctrl[0] && d[5:0] <= 32) m_fsize = d;
        3: m_raw = m_raw & ~d[2:0];
        5: if (txq.size() < dep) txq.push_back(d);
        6: m_cdiv = d;
        7: m_ss = d;
        default: ;
      endcase
      if (rd && a == 4) begin
        if (rxq.size()) void'(rxq.pop_front());
        m_ovf = 0;
      end
      if (st) m_done = 0;
      if (dn) begin m_done = 1; m_raw[1:0] = 2'b11; end
      if (pop) void'(txq.pop_front());
      if (push) begin
        if (rxq.size() < dep) rxq.push_back(pd);
        else begin m_ovf = 1; m_raw[2] = 1; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; tx_pop = 0; rx_push = 0; xfer_start = 0; xfer_done = 0;
    if (rd) check(tag, bus_rdata, exp_rd);
    check("R10 irq", {31'b0, irq}, {31'b0, |m_masked()});
    check("R5 tx_empty", {31'b0, tx_empty}, {31'b0, txq.size() == 0});
  endtask

  task automatic wr(int a, bit [31:0] d);
    step(1, 0, a, d, 0, 0, 0, 0, 0, "");
  endtask
  task automatic rd(int a, string tag);
    step(0, 1, a, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rxin(bit [31:0] v);
    step(0, 0, 0, 0, 0, 1, v, 0, 0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd(0, "R1 ctrl"); rd(1, "R1 fsize"); rd(6, "R1 cdiv"); rd(2, "R1 status");
    check("R1 status literal", m_status(), 32'h2440);
    // R2 plain registers and zero-reading offsets
    wr(6, 32'h55); wr(7, 32'h3);
    rd(6, "R2 cdiv"); rd(7, "R2 ssel"); rd(3, "R2 iclr"); rd(5, "R2 txd"); rd(12, "R2 hole");
    // R5/R8 TX fill beyond depth 4
    for (int i = 0; i < 5; i++) begin
      wr(5, 32'hA0 + i);
      rd(2, "R8 tx status");
    end
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, 0, 0, 0, "");
    rd(2, "R8 tx drained");
    // R6/R8 RX path
    for (int i = 0; i < 3; i++) begin
      rxin(32'hB0 + i);
      rd(2, "R8 rx status");
    end
    for (int i = 0; i < 4; i++) rd(4, "R6 rx read");
    // R7 overflow, R11 clear
    for (int i = 0; i < 5; i++) rxin(32'hC0 + i);
    rd(2, "R7 status ovf"); rd(9, "R7 raw ovf");
    rd(4, "R6 rx read"); rd(2, "R6 ovf cleared");
    rd(9, "R11 raw kept");
    wr(3, 32'h4); rd(9, "R11 raw cleared");
    for (int i = 0; i < 3; i++) rd(4, "R6 rx drain");
    // R10 enable remapping
    wr(0, 32'h0000_0140);
    for (int i = 0; i < 5; i++) rxin(32'hD0 + i);
    rd(8, "R10 masked ovf");
    wr(0, 32'h0000_0110);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "");
    rd(8, "R10 masked rx"); rd(2, "R9 done set"); rd(9, "R9 raw set");
    wr(0, 32'h0000_0120); rd(8, "R10 masked tx");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, "");
    rd(2, "R9 start clears"); rd(9, "R9 raw stays");
    wr(3, 32'h7); rd(9, "R11 all cleared");
    // R11 read-only offsets
    wr(2, 32'hFFFF_FFFF); wr(8, 32'h7); wr(9, 32'h7); wr(4, 32'h1234);
    rd(2, "R11 status ro"); rd(9, "R11 raw ro"); rd(4, "R11 rxd ro");
    // R4 frame size lock and limit
    wr(0, 32'h0000_0101); wr(1, 32'd16); rd(1, "R4 locked");
    wr(0, 32'h0000_0100); wr(1, 32'd40); rd(1, "R4 too big");
    wr(1, 32'd32); rd(1, "R4 accepted");
    // R3 deep FIFO depths, R12 soft reset between
    wr(1, 32'd8); wr(0, 32'h2000_0000);
    for (int i = 0; i < 33; i++) wr(5, i);
    rd(2, "R3 depth 32");
    wr(0, 32'h8000_0000); rd(2, "R12 status"); rd(0, "R12 ctrl"); rd(6, "R12 cdiv");
    wr(1, 32'd12); wr(0, 32'h2000_0000);
    for (int i = 0; i < 17; i++) wr(5, i);
    rd(2, "R3 depth 16");
    wr(0, 32'h8000_0000);
    wr(1, 32'd20); wr(0, 32'h2000_0000);
    for (int i = 0; i < 9; i++) wr(5, i);
    rd(2, "R3 depth 8");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, "");
    rd(2, "R3 full-next");
    seq_active = 1; sel_line = 0;
    rd(2, "R1 live bits");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule